// File: doc/BRIEF.md
# Programmable Chip-Select External Bus Sequencer

This block converts single read or write requests from an internal bus into cycles on an external parallel memory-mapped bus with eight chip selects. The upper three bits of the request address pick a chip select, and each chip select owns a 16 MiB window addressed by the lower 24 bits. Every chip select has its own configuration register. That register holds five phase stretch values, a strobe protocol, an 8-bit or 16-bit data width, optional address/data multiplexing, a write permission bit and a ready polarity.

An accepted request walks through five phases in a fixed order: address, chip-select setup, strobe, hold and recovery. Each phase lasts one cycle plus its own stretch value. The block drives the address, data, chip-select and strobe pins from the phase state. Read data is taken on the last strobe cycle. The response is a one-cycle done pulse that carries the read data and an error flag. The configuration registers sit in their own small register space, addressed by chip-select number, and they can be read back.

Top module: `extbus_seq`

## Requirements
- R1: The chip select is request address bits [26:24] and the window offset is bits [23:0]. Only that chip select's active-low line is driven low, and only during the setup, strobe and hold phases. The offset is on the address pins during all five phases and the pins read zero when idle.
- R2: The phases run address, setup, strobe, hold, recovery. Each lasts 1 + n cycles, where n comes from config bits [1:0] (address), [3:2] (setup), [7:4] (strobe), [9:8] (hold) and [13:10] (recovery). The done pulse comes in the cycle after the last recovery cycle.
- R3: Strobes are active only in the strobe phase. With protocol bits [15:14] = 0, or the reserved value 3, a read pulses the read strobe low and a write pulses the write strobe low.
- R4: With protocol 1, the direction line is low for a write and high for a read during all five phases, and a single data strobe is low in the strobe phase. The separate read and write strobes stay high.
- R5: With protocol 2, the strobes behave as in protocol 0, but the strobe phase only ends once its count has run out and the ready input is active. Ready is active high when config bit [20] is 1 and active low when it is 0.
- R6: When config bit [16] is set, the bus is 8 bits wide. Write data pins [15:8] are driven 0 and read data bits [15:8] are returned as 0. The same masking applies to any byte request on a 16-bit chip select.
- R7: A byte read on a 16-bit chip select whose config bit [17] is clear completes with done and error one cycle after acceptance. No chip select or strobe is driven.
- R8: A write to a chip select whose config bit [19] is clear completes with done and error one cycle after acceptance. No chip select or strobe is driven.
- R9: When config bit [18] is set, the data pins carry offset bits [15:0] and the latch-enable output is high during the address phase only. Write data uses the same pins from setup through hold.
- R10: Read data is sampled from the data inputs on the last strobe cycle and is presented with the done pulse. Successful writes and error responses return zero.
- R11: The configuration registers reset to zero and read back exactly the bits written, selected by chip-select number. A register write made during an access does not change that access.
- R12: A request that arrives while an access is in progress is ignored.
- R13: After reset, all chip selects and strobes are high, the direction line is high, latch enable and data drive are low, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request pulse, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte access, 0 = 16-bit access |
| reqAddr | input | 27 | Chip select [26:24] and window offset [23:0] |
| reqWdata | input | 16 | Write data |
| respDone | output | 1 | One-cycle completion pulse |
| respErr | output | 1 | Error flag, valid with respDone |
| respRdata | output | 16 | Read data, valid with respDone |
| cfgWrite | input | 1 | Configuration register write strobe |
| cfgSel | input | 3 | Configuration register select (chip-select number) |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Read-back of the selected configuration register |
| busAddr | output | 24 | External address pins |
| busDataOut | output | 16 | External data output |
| busDataOe | output | 1 | External data output enable |
| busDataIn | input | 16 | External data input |
| busCsN | output | 8 | Active-low chip selects |
| busAle | output | 1 | Address latch enable for multiplexed mode |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busRnw | output | 1 | Direction line for protocol 1 |
| busDsN | output | 1 | Active-low data strobe for protocol 1 |
| busRdy | input | 1 | Ready input for protocol 2 |

## Verification
A phase counter that is off by one shows up at the pins in the same cycle. A strobe then opens or closes one cycle early or late, and because the reference model is compared every clock, the error is caught at that edge. A wrong latched configuration or chip-select index turns a different chip-select line low or picks a different strobe style as soon as the setup phase starts. A wrong sampling point only shows at the done pulse, as a read value from a different cycle, because the data inputs change every cycle. Ignored requests and configuration writes made during an access would bend the pin sequence of the access in progress within a cycle or two.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int DATA_W = 16;
  localparam int CFG_W  = 21;

  localparam logic [1:0] PROTO_SPLIT = 2'd0;
  localparam logic [1:0] PROTO_COMB  = 2'd1;
  localparam logic [1:0] PROTO_HOST  = 2'd2;

  // bit 20 down to bit 0
  typedef struct packed {
    logic       rdyHigh;
    logic       wrEn;
    logic       muxAd;
    logic       byteRdOk;
    logic       narrow;
    logic [1:0] proto;
    logic [3:0] tRecov;
    logic [1:0] tHold;
    logic [3:0] tStrobe;
    logic [1:0] tSetup;
    logic [1:0] tAddr;
  } csCfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_t;

  typedef struct packed {
    phase_t phase;
    logic   start;
    logic   sample;
  } ctl_t;
endpackage

// File: rtl/extbus_cfg_regs.sv
module extbus_cfg_regs
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrite,
  input  logic [CS_W-1:0] cfgSel,
  input  logic [31:0]     cfgWdata,
  output logic [31:0]     cfgRdata,
  output csCfg_t          cfgAll [NUM_CS]
);
  logic unusedHighBits;
  assign unusedHighBits = ^cfgWdata[31:CFG_W];

  for (genvar g = 0; g < NUM_CS; g++) begin : gCs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgAll[g] <= '0;
      else if (cfgWrite && cfgSel == CS_W'(g)) cfgAll[g] <= csCfg_t'(cfgWdata[CFG_W-1:0]);
    end
  end

  assign cfgRdata = {{(32-CFG_W){1'b0}}, cfgAll[cfgSel]};
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   reqByte,
  input  csCfg_t selCfg,
  input  csCfg_t curCfg,
  input  logic   busRdy,
  output ctl_t   ctl,
  output logic   respDone,
  output logic   respErr
);
  phase_t     phase;
  logic [3:0] cnt;
  logic       start, reqBad, hostMode, rdyAct, cntZero, phaseEnd, okDone;

  logic unusedFields;
  assign unusedFields = ^{selCfg.tSetup, selCfg.tStrobe, selCfg.tHold, selCfg.tRecov,
                          selCfg.proto, selCfg.muxAd, selCfg.rdyHigh, curCfg.tAddr,
                          curCfg.narrow, curCfg.byteRdOk, curCfg.muxAd, curCfg.wrEn};

  function automatic logic [3:0] extOf(phase_t p, csCfg_t c);
    case (p)
      PH_SETUP:  extOf = {2'b00, c.tSetup};
      PH_STROBE: extOf = c.tStrobe;
      PH_HOLD:   extOf = {2'b00, c.tHold};
      PH_RECOV:  extOf = c.tRecov;
      default:   extOf = '0;
    endcase
  endfunction

  assign start    = reqValid && phase == PH_IDLE;
  assign reqBad   = reqWrite ? !selCfg.wrEn : (reqByte && !selCfg.narrow && !selCfg.byteRdOk);
  assign hostMode = curCfg.proto == PROTO_HOST;
  assign rdyAct   = curCfg.rdyHigh ? busRdy : !busRdy;
  assign cntZero  = cnt == '0;
  assign phaseEnd = cntZero && !(phase == PH_STROBE && hostMode && !rdyAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      respDone <= 1'b0;
      respErr  <= 1'b0;
      okDone   <= 1'b0;
    end else begin
      respDone <= 1'b0;
      respErr  <= 1'b0;
      okDone   <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          if (reqBad) begin
            respDone <= 1'b1;
            respErr  <= 1'b1;
          end else begin
            phase <= PH_ADDR;
            cnt   <= {2'b00, selCfg.tAddr};
          end
        end
      end else if (!cntZero) begin
        cnt <= cnt - 4'd1;
      end else if (phaseEnd) begin
        if (phase == PH_RECOV) begin
          phase    <= PH_IDLE;
          respDone <= 1'b1;
          okDone   <= 1'b1;
        end else begin
          phase <= phase_t'(phase + 3'd1);
          cnt   <= extOf(phase_t'(phase + 3'd1), curCfg);
        end
      end
    end
  end

  assign ctl.phase  = phase;
  assign ctl.start  = start;
  assign ctl.sample = phase == PH_STROBE && phaseEnd;

  assert_setup_after_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> $past(phase) == PH_ADDR);
  assert_recov_after_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RECOV && $past(phase) != PH_RECOV) |-> $past(phase) == PH_HOLD);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    okDone |=> !okDone);
  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && reqWrite && !selCfg.wrEn) |=> (phase == PH_IDLE && respErr));
  assert_host_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && hostMode && !rdyAct) |=> phase == PH_STROBE);
endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int WIN_W  = 24,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int ADDR_W = CS_W + WIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] reqWdata,
  input  csCfg_t            selCfg,
  input  logic [DATA_W-1:0] busDataIn,
  output csCfg_t            curCfg,
  output logic [DATA_W-1:0] respRdata,
  output logic [WIN_W-1:0]  busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [NUM_CS-1:0] busCsN,
  output logic              busAle,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busRnw,
  output logic              busDsN
);
  logic [CS_W-1:0]   lCs;
  logic [WIN_W-1:0]  lOff;
  logic              lWrite, lByte;
  logic [DATA_W-1:0] lWdata;
  logic              active, csOn, strobeOn, combo, addrDrive, dataDrive, lowOnly;

  assign lowOnly = curCfg.narrow || lByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lCs       <= '0;
      lOff      <= '0;
      lWrite    <= 1'b0;
      lByte     <= 1'b0;
      lWdata    <= '0;
      curCfg    <= '0;
      respRdata <= '0;
    end else if (ctl.start) begin
      lCs       <= reqAddr[ADDR_W-1 -: CS_W];
      lOff      <= reqAddr[WIN_W-1:0];
      lWrite    <= reqWrite;
      lByte     <= reqByte;
      lWdata    <= reqWdata;
      curCfg    <= selCfg;
      respRdata <= '0;
    end else if (ctl.sample && !lWrite) begin
      respRdata <= lowOnly ? {{(DATA_W-8){1'b0}}, busDataIn[7:0]} : busDataIn;
    end
  end

  assign active    = ctl.phase != PH_IDLE;
  assign csOn      = ctl.phase inside {PH_SETUP, PH_STROBE, PH_HOLD};
  assign strobeOn  = ctl.phase == PH_STROBE;
  assign combo     = curCfg.proto == PROTO_COMB;
  assign addrDrive = ctl.phase == PH_ADDR && curCfg.muxAd;
  assign dataDrive = lWrite && csOn;

  assign busCsN     = csOn ? ~(NUM_CS'(1) << lCs) : '1;
  assign busAddr    = active ? lOff : '0;
  assign busAle     = addrDrive;
  assign busDataOe  = addrDrive || dataDrive;
  assign busDataOut = addrDrive ? lOff[DATA_W-1:0] :
                      dataDrive ? (lowOnly ? {{(DATA_W-8){1'b0}}, lWdata[7:0]} : lWdata) : '0;
  assign busRdN     = !(strobeOn && !combo && !lWrite);
  assign busWrN     = !(strobeOn && !combo && lWrite);
  assign busDsN     = !(strobeOn && combo);
  assign busRnw     = (active && combo) ? !lWrite : 1'b1;

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~busCsN));
  assert_rd_wr_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN));
  assert_strobe_under_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN || !busWrN || !busDsN) |-> busCsN != '1);
  assert_ale_no_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> busCsN == '1);
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int WIN_W  = 24,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int ADDR_W = CS_W + WIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              respDone,
  output logic              respErr,
  output logic [15:0]       respRdata,
  input  logic              cfgWrite,
  input  logic [CS_W-1:0]   cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  output logic [WIN_W-1:0]  busAddr,
  output logic [15:0]       busDataOut,
  output logic              busDataOe,
  input  logic [15:0]       busDataIn,
  output logic [NUM_CS-1:0] busCsN,
  output logic              busAle,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busRnw,
  output logic              busDsN,
  input  logic              busRdy
);
  csCfg_t cfgAll [NUM_CS];
  csCfg_t selCfg, curCfg;
  ctl_t   ctl;

  assign selCfg = cfgAll[reqAddr[ADDR_W-1 -: CS_W]];

  extbus_cfg_regs #(.NUM_CS(NUM_CS)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfgAll(cfgAll));

  extbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqByte(reqByte), .selCfg(selCfg), .curCfg(curCfg), .busRdy(busRdy),
    .ctl(ctl), .respDone(respDone), .respErr(respErr));

  extbus_datapath #(.NUM_CS(NUM_CS), .WIN_W(WIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqByte(reqByte), .reqWdata(reqWdata), .selCfg(selCfg), .busDataIn(busDataIn),
    .curCfg(curCfg), .respRdata(respRdata), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busCsN(busCsN),
    .busAle(busAle), .busRdN(busRdN), .busWrN(busWrN), .busRnw(busRnw),
    .busDsN(busDsN));
endmodule

// File: tb/extbus_seq_bench.sv
module extbus_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqByte = 1'b0;
  logic [26:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        respDone, respErr;
  logic [15:0] respRdata;
  logic        cfgWrite = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [23:0] busAddr;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [15:0] busDataIn = '0;
  logic [7:0]  busCsN;
  logic        busAle, busRdN, busWrN, busRnw, busDsN;
  logic        busRdy = 1'b0;

  int total = 0, bad = 0, cycles = 0, rdyWait = 0;

  // reference model state
  logic [20:0] mCfg [8];
  int          mPh = 0, mCnt = 0;
  logic [2:0]  mCs = '0;
  logic [23:0] mOff = '0;
  logic        mWr = 1'b0, mByte = 1'b0;
  logic [15:0] mWd = '0;
  logic [20:0] mLc = '0;
  logic        eDone = 1'b0, eErr = 1'b0;
  logic [15:0] eRd = '0;

  extbus_seq u_extbus_seq (.*);

  always #10 clk = ~clk;

  initial for (int i = 0; i < 8; i++) mCfg[i] = '0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int extOf(int ph, logic [20:0] c);
    case (ph)
      1: return int'(c[1:0]);
      2: return int'(c[3:2]);
      3: return int'(c[7:4]);
      4: return int'(c[9:8]);
      default: return int'(c[13:10]);
    endcase
  endfunction

  // model step on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPh = 0; mCnt = 0; eDone = 0; eErr = 0; eRd = '0;
      for (int i = 0; i < 8; i++) mCfg[i] = '0;
    end else begin
      logic [20:0] c;
      logic        hp, act, isBad;
      eDone = 0; eErr = 0;
      hp  = mLc[15:14] == 2'd2;
      act = mLc[20] ? busRdy : !busRdy;
      if (mPh == 0) begin
        if (reqValid) begin
          c = mCfg[reqAddr[26:24]];
          isBad = reqWrite ? !c[19] : (reqByte && !c[16] && !c[17]);
          mCs = reqAddr[26:24]; mOff = reqAddr[23:0]; mWr = reqWrite;
          mByte = reqByte; mWd = reqWdata; mLc = c; eRd = '0;
          if (isBad) begin eDone = 1; eErr = 1; end
          else begin mPh = 1; mCnt = int'(c[1:0]); end
        end
      end else if (mCnt != 0) begin
        mCnt--;
      end else if (!(mPh == 3 && hp && !act)) begin
        if (mPh == 3 && !mWr) eRd = (mLc[16] || mByte) ? {8'h00, busDataIn[7:0]} : busDataIn;
        if (mPh == 5) begin mPh = 0; eDone = 1; end
        else begin mPh++; mCnt = extOf(mPh, mLc); end
      end
      if (cfgWrite) mCfg[cfgSel] = cfgWdata[20:0];
    end
  end

  // compare on falling edge, then update bus-side inputs
  always @(negedge clk) begin
    logic        csOn, strb, combo, lowOnly, aDrv, dDrv;
    logic [7:0]  xCs;
    logic [15:0] xDo;
    csOn    = mPh >= 2 && mPh <= 4;
    strb    = mPh == 3;
    combo   = mLc[15:14] == 2'd1;
    lowOnly = mLc[16] || mByte;
    aDrv    = mPh == 1 && mLc[18];
    dDrv    = mWr && csOn;
    xCs     = csOn ? ~(8'd1 << mCs) : 8'hFF;
    xDo     = aDrv ? mOff[15:0] : (lowOnly ? {8'h00, mWd[7:0]} : mWd);
    cmp("R1 busCsN", 32'(busCsN), 32'(xCs));
    cmp("R1 busAddr", 32'(busAddr), (mPh != 0) ? 32'(mOff) : 32'd0);
    cmp("R3 R5 busRdN", 32'(busRdN), 32'(!(strb && !combo && !mWr)));
    cmp("R3 R5 busWrN", 32'(busWrN), 32'(!(strb && !combo && mWr)));
    cmp("R4 busDsN", 32'(busDsN), 32'(!(strb && combo)));
    cmp("R4 busRnw", 32'(busRnw), (mPh != 0 && combo) ? 32'(!mWr) : 32'd1);
    cmp("R9 busAle", 32'(busAle), 32'(aDrv));
    cmp("R9 busDataOe", 32'(busDataOe), 32'(aDrv || dDrv));
    if (aDrv || dDrv) cmp("R6 R9 busDataOut", 32'(busDataOut), 32'(xDo));
    cmp("R2 R5 R12 respDone", 32'(respDone), 32'(eDone));
    if (eDone) begin
      cmp("R7 R8 respErr", 32'(respErr), 32'(eErr));
      cmp("R6 R10 respRdata", 32'(respRdata), 32'(eRd));
    end
    cmp("R11 cfgRdata", cfgRdata, 32'(mCfg[cfgSel]));
    busDataIn = 16'(cycles * 16'h0137) ^ 16'h5A5A;
    busRdy    = mLc[20] ? (rdyWait == 0) : (rdyWait != 0);
    if (mPh == 3 && rdyWait > 0) rdyWait--;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles == 150000) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(int ta, int ts, int tb, int th, int tr, int pr,
                                     bit nar, bit bok, bit mux, bit wen, bit rhi);
    return {11'd0, rhi, wen, mux, bok, nar, 2'(pr), 4'(tr), 2'(th), 4'(tb), 2'(ts), 2'(ta)};
  endfunction

  task automatic setCfg(int cs, logic [31:0] v);
    @(negedge clk); #1;
    cfgWrite = 1; cfgSel = 3'(cs); cfgWdata = v;
    @(negedge clk); #1;
    cfgWrite = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (mPh == 0 && !eDone) break;
    end
  endtask

  task automatic go(bit wr, int cs, logic [23:0] off, logic [15:0] wd, bit byt, int rw);
    @(negedge clk); #1;
    rdyWait = rw;
    reqValid = 1; reqWrite = wr; reqByte = byt; reqAddr = {3'(cs), off}; reqWdata = wd;
    @(negedge clk); #1;
    reqValid = 0;
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    cmp("R13 csN", 32'(busCsN), 32'hFF);
    cmp("R13 strobes", 32'({busRdN, busWrN, busDsN, busRnw}), 32'hF);
    cmp("R13 ale oe", 32'({busAle, busDataOe}), 32'h0);
    cmp("R13 done", 32'(respDone), 32'h0);
    cmp("R13 R11 cfg reset", cfgRdata, 32'h0);
    #1 rstN = 1;

    setCfg(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    setCfg(1, mk(1, 1, 2, 1, 1, 0, 0, 0, 0, 0, 0));
    setCfg(2, mk(0, 1, 1, 0, 2, 0, 0, 0, 0, 1, 0));
    setCfg(3, mk(3, 2, 15, 1, 15, 1, 0, 0, 0, 1, 0));
    setCfg(4, mk(1, 0, 3, 2, 0, 0, 0, 1, 0, 1, 0));
    setCfg(5, mk(0, 1, 2, 1, 1, 2, 0, 0, 0, 1, 1));
    setCfg(6, mk(2, 0, 0, 3, 4, 2, 0, 0, 1, 1, 0));
    setCfg(7, mk(1, 3, 5, 0, 3, 0, 1, 0, 1, 1, 0));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 cfgSel = 3'(i);   // R11 read-back compared every cycle
    end

    go(1, 0, 24'h123456, 16'hBEEF, 0, 0);   // R2 R3 minimum phases
    go(0, 0, 24'h00ABCD, 16'h0, 0, 0);
    go(0, 3, 24'hFFFFFF, 16'h0, 0, 0);      // R4 long phases
    go(1, 3, 24'h000001, 16'hC3C3, 0, 0);
    go(0, 5, 24'h0A0B0C, 16'h0, 0, 4);      // R5 ready high, waits
    go(1, 5, 24'h000200, 16'h1234, 0, 0);
    go(0, 6, 24'h777777, 16'h0, 0, 7);      // R5 ready low, R9 mux
    go(1, 6, 24'h00F0F0, 16'hA55A, 0, 0);
    go(1, 7, 24'h13579B, 16'h9876, 0, 0);   // R6 narrow
    go(0, 7, 24'h2468AC, 16'h0, 0, 0);
    go(1, 1, 24'h000010, 16'h1111, 0, 0);   // R8 blocked write
    go(0, 1, 24'h000010, 16'h0, 0, 0);
    go(0, 2, 24'h000020, 16'h0, 1, 0);      // R7 byte read refused
    go(1, 2, 24'h000021, 16'hABCD, 1, 0);   // byte write allowed
    go(0, 4, 24'h000030, 16'h0, 1, 0);      // R7 byte read allowed
    setCfg(2, mk(1, 0, 2, 0, 1, 3, 0, 0, 0, 1, 0));
    go(0, 2, 24'h000040, 16'h0, 0, 0);      // R3 reserved protocol
    go(1, 2, 24'h000041, 16'h4242, 0, 0);

    // R12 and R11: stray request and config write during an access
    @(negedge clk); #1;
    reqValid = 1; reqWrite = 0; reqByte = 0; reqAddr = {3'd3, 24'h55AA55};
    @(negedge clk); #1;
    reqValid = 0;
    repeat (4) @(negedge clk);
    #1 reqValid = 1; reqWrite = 1; reqAddr = {3'd0, 24'h000099}; reqWdata = 16'h7777;
    cfgWrite = 1; cfgSel = 3'd3; cfgWdata = mk(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    @(negedge clk); #1;
    reqValid = 0; cfgWrite = 0;
    waitIdle();
    go(0, 3, 24'h000100, 16'h0, 0, 0);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule